// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic datapath of a small accumulator-style processor. It works on 8-bit operands and can be switched to 16-bit operation for each operation. A 4-bit operation code picks one of fifteen functions: binary add and subtract, each with or without the stored carry, bitwise logic, rotates and shifts, single-bit test, carry manipulation, and packed-BCD correction. The result is combinational from the operands, the operation and the stored flags.

Six status flags sit in one register: sign, zero, half-carry, parity/overflow, add/subtract and carry. The instruction sequencer asserts a write strobe in the cycle an operation completes, and the flags are captured at that clock edge. Later operations read the stored carry as a carry-in. A decimal-adjust operation reads the stored add/subtract, half-carry and carry flags to choose its correction. Decoding, memory access and interrupt handling live elsewhere.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low the flag register is all zeros. `flags_o` packs sign in bit 7, zero in bit 6, half-carry in bit 4, parity/overflow in bit 2, add/subtract in bit 1 and carry in bit 0. Bits 5 and 3 always read 0.
- R2: The flags change only at a rising clock edge with `wr_en_i` high, and otherwise hold. Operation code 15 passes `a_i` to the result and leaves the flags unchanged.
- R3: Code 0 adds, code 1 adds the stored carry as well, code 2 subtracts and code 3 also subtracts the stored carry. Carry becomes the carry-out of an add or the borrow of a subtract. Add ops clear N and subtract ops set N.
- R4: After codes 0 to 3 the parity/overflow flag is 1 exactly when the two's-complement result overflows. For an add this means equal operand signs and a result sign that differs. For a subtract it means differing operand signs and a result sign that differs from `a_i`.
- R5: Half-carry after codes 0 to 3 is the carry or borrow into bit 4 when `wide_i` is 0, and into bit 12 when `wide_i` is 1.
- R6: With `wide_i` at 0 only bits 7:0 of the operands count and `res_o[15:8]` is 0. For every code except 11, 12, 13 and 15, sign copies the result MSB (bit 7, or bit 15 when wide) and zero is 1 exactly when the result is 0.
- R7: Codes 4 (AND), 5 (OR) and 6 (XOR) clear carry and N. Half-carry becomes 1 for AND and 0 for OR and XOR. Parity/overflow becomes 1 when the result has an even number of set bits.
- R8: Code 7 rotates left through carry and code 8 rotates right through carry. Code 9 shifts left with a 0 in, and code 10 shifts right with a 0 in. Carry receives the bit moved out. Half-carry and N clear, and parity/overflow holds the even parity of the result.
- R9: Code 11 tests bit `b_i[3:0]` of `a_i`, or bit `b_i[2:0]` when narrow. Zero becomes the inverse of that bit, half-carry becomes 1 and N clears. Sign, parity/overflow and carry keep their values, and the result equals `a_i`.
- R10: Code 12 sets carry and code 13 inverts carry. Both clear half-carry and N, keep sign, zero and parity/overflow, and return `a_i`.
- R11: Code 14 adjusts `a_i[7:0]` as packed BCD, whatever `wide_i` is. The low correction 0x06 applies when the low nibble is above 9 or half-carry is set. The high correction 0x60 applies when the byte is above 0x99 or carry is set, and it also sets carry; otherwise carry keeps its value. The corrections are added when N is 0 and subtracted when N is 1. N is kept, half-carry becomes bit 4 of the operand XOR the result, and parity/overflow is the even parity of the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| a_i | input | 16 | First operand (accumulator) |
| b_i | input | 16 | Second operand, or bit index for bit test |
| op_i | input | 4 | Operation code |
| wide_i | input | 1 | 1 selects 16-bit operation |
| wr_en_i | input | 1 | Capture the new flags at this clock edge |
| res_o | output | 16 | Combinational result |
| flags_o | output | 8 | Stored flag register |

## Verification
Arithmetic is driven with operand pairs chosen to separate signed overflow from unsigned carry, to toggle the nibble carry on its own, and to differ only in the stored carry-in. Each pattern is also run in 16-bit mode, so a half-carry taken at the wrong boundary shows up. Logic and shift patterns use results of odd and even weight, so the parity meaning of the shared flag is told apart from overflow. Decimal adjust is run after adds and after subtracts with and without stored half-carry and carry, which checks that the stored N selects the direction of the correction. Writes with the strobe low show whether the flags hold.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_RLC  = 4'd7,
        OP_RRC  = 4'd8,
        OP_SHL  = 4'd9,
        OP_SHR  = 4'd10,
        OP_BTST = 4'd11,
        OP_STC  = 4'd12,
        OP_CMC  = 4'd13,
        OP_DADJ = 4'd14,
        OP_PASS = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic h;
        logic pv;
        logic n;
        logic c;
    } alu_flags_t;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
    parameter int NARROW_W = 8,
    parameter int NIB_W    = 4
) (
    input  logic [2*NARROW_W-1:0] a_i,
    input  logic [2*NARROW_W-1:0] b_i,
    input  logic                  wide_i,
    input  logic                  sub_i,
    input  logic                  cin_i,
    output logic [2*NARROW_W-1:0] res_o,
    output logic                  c_o,
    output logic                  h_o,
    output logic                  v_o
);
    localparam int WIDE_W = 2 * NARROW_W;
    localparam int HB_N   = NARROW_W - NIB_W;
    localparam int HB_W   = WIDE_W - NIB_W;

    logic [WIDE_W-1:0] mask;
    logic [WIDE_W-1:0] am;
    logic [WIDE_W-1:0] bm;
    logic [WIDE_W:0]   total;
    logic [WIDE_W-1:0] carries;
    logic              sa;
    logic              sb;
    logic              sr;

    always_comb begin
        mask  = wide_i ? {WIDE_W{1'b1}} : {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
        am    = a_i & mask;
        bm    = b_i & mask;
        if (sub_i) begin
            total = {1'b0, am} - {1'b0, bm} - {{WIDE_W{1'b0}}, cin_i};
        end else begin
            total = {1'b0, am} + {1'b0, bm} + {{WIDE_W{1'b0}}, cin_i};
        end
        res_o   = total[WIDE_W-1:0] & mask;
        carries = am ^ bm ^ total[WIDE_W-1:0];
        c_o     = wide_i ? total[WIDE_W] : total[NARROW_W];
        h_o     = wide_i ? carries[HB_W] : carries[HB_N];
        sa      = wide_i ? am[WIDE_W-1] : am[NARROW_W-1];
        sb      = wide_i ? bm[WIDE_W-1] : bm[NARROW_W-1];
        sr      = wide_i ? res_o[WIDE_W-1] : res_o[NARROW_W-1];
        v_o     = sub_i ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
    end

endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
    import acc_alu_pkg::*;
#(
    parameter int NARROW_W = 8,
    parameter int IDX_W    = 4
) (
    input  logic [2*NARROW_W-1:0] a_i,
    input  logic [2*NARROW_W-1:0] b_i,
    input  logic [IDX_W-1:0]      idx_i,
    input  logic                  wide_i,
    input  alu_op_e               op_i,
    input  logic                  cin_i,
    output logic [2*NARROW_W-1:0] res_o,
    output logic                  c_o,
    output logic                  bit_o
);
    localparam int WIDE_W = 2 * NARROW_W;

    logic [WIDE_W-1:0] mask;
    logic [WIDE_W-1:0] am;
    logic [WIDE_W-1:0] bm;
    logic [WIDE_W-1:0] top_bit;
    logic [IDX_W-1:0]  idx;
    logic              msb;

    always_comb begin
        mask    = wide_i ? {WIDE_W{1'b1}} : {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
        am      = a_i & mask;
        bm      = b_i & mask;
        top_bit = wide_i ? {1'b1, {(WIDE_W-1){1'b0}}}
                         : {{(WIDE_W-NARROW_W){1'b0}}, 1'b1, {(NARROW_W-1){1'b0}}};
        msb     = wide_i ? am[WIDE_W-1] : am[NARROW_W-1];
        idx     = wide_i ? idx_i : {1'b0, idx_i[IDX_W-2:0]};
        bit_o   = am[idx];
        res_o   = am;
        c_o     = 1'b0;
        case (op_i)
            OP_AND: res_o = am & bm;
            OP_OR:  res_o = am | bm;
            OP_XOR: res_o = am ^ bm;
            OP_RLC: begin
                res_o = ((am << 1) | {{(WIDE_W-1){1'b0}}, cin_i}) & mask;
                c_o   = msb;
            end
            OP_RRC: begin
                res_o = (am >> 1) | (cin_i ? top_bit : '0);
                c_o   = am[0];
            end
            OP_SHL: begin
                res_o = (am << 1) & mask;
                c_o   = msb;
            end
            OP_SHR: begin
                res_o = am >> 1;
                c_o   = am[0];
            end
            default: res_o = am;
        endcase
    end

endmodule

// File: rtl/acc_alu_bcd.sv
module acc_alu_bcd #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] a_i,
    input  logic              n_i,
    input  logic              h_i,
    input  logic              c_i,
    output logic [BYTE_W-1:0] res_o,
    output logic              c_o,
    output logic              h_o
);
    localparam int          NIB_W  = BYTE_W / 2;
    localparam logic [BYTE_W-1:0] LO_FIX = BYTE_W'(6);
    localparam logic [BYTE_W-1:0] HI_FIX = BYTE_W'(6) << NIB_W;
    localparam logic [BYTE_W-1:0] HI_LIM = BYTE_W'(8'h99);

    logic [BYTE_W-1:0] corr;
    logic              lo_fix;
    logic              hi_fix;

    always_comb begin
        lo_fix = (a_i[NIB_W-1:0] > NIB_W'(9)) || h_i;
        hi_fix = (a_i > HI_LIM) || c_i;
        corr   = (lo_fix ? LO_FIX : '0) | (hi_fix ? HI_FIX : '0);
        res_o  = n_i ? (a_i - corr) : (a_i + corr);
        c_o    = hi_fix;
        h_o    = a_i[NIB_W] ^ res_o[NIB_W];
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int NARROW_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*NARROW_W-1:0] a_i,
    input  logic [2*NARROW_W-1:0] b_i,
    input  logic [3:0]            op_i,
    input  logic                  wide_i,
    input  logic                  wr_en_i,
    output logic [2*NARROW_W-1:0] res_o,
    output logic [7:0]            flags_o
);
    localparam int WIDE_W = 2 * NARROW_W;
    localparam int IDX_W  = $clog2(WIDE_W);

    alu_op_e    op;
    alu_flags_t flags_d;
    alu_flags_t flags_q;

    logic [WIDE_W-1:0]   as_res;
    logic                as_c;
    logic                as_h;
    logic                as_v;
    logic [WIDE_W-1:0]   bo_res;
    logic                bo_c;
    logic                bo_bit;
    logic [NARROW_W-1:0] bcd_res;
    logic                bcd_c;
    logic                bcd_h;
    logic                is_sub;
    logic                use_cin;
    logic                msb_wide;
    logic [WIDE_W-1:0]   res_d;
    logic [WIDE_W-1:0]   a_m;

    assign op      = alu_op_e'(op_i);
    assign is_sub  = (op == OP_SUB) || (op == OP_SBC);
    assign use_cin = ((op == OP_ADC) || (op == OP_SBC)) && flags_q.c;

    acc_alu_addsub #(.NARROW_W(NARROW_W), .NIB_W(4)) addsub_i (
        .a_i    (a_i),
        .b_i    (b_i),
        .wide_i (wide_i),
        .sub_i  (is_sub),
        .cin_i  (use_cin),
        .res_o  (as_res),
        .c_o    (as_c),
        .h_o    (as_h),
        .v_o    (as_v)
    );

    acc_alu_bitops #(.NARROW_W(NARROW_W), .IDX_W(IDX_W)) bitops_i (
        .a_i    (a_i),
        .b_i    (b_i),
        .idx_i  (b_i[IDX_W-1:0]),
        .wide_i (wide_i),
        .op_i   (op),
        .cin_i  (flags_q.c),
        .res_o  (bo_res),
        .c_o    (bo_c),
        .bit_o  (bo_bit)
    );

    acc_alu_bcd #(.BYTE_W(NARROW_W)) bcd_i (
        .a_i   (a_i[NARROW_W-1:0]),
        .n_i   (flags_q.n),
        .h_i   (flags_q.h),
        .c_i   (flags_q.c),
        .res_o (bcd_res),
        .c_o   (bcd_c),
        .h_o   (bcd_h)
    );

    // next result and next flags
    always_comb begin
        a_m      = wide_i ? a_i : {{(WIDE_W-NARROW_W){1'b0}}, a_i[NARROW_W-1:0]};
        flags_d  = flags_q;
        msb_wide = wide_i;
        res_d    = a_m;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                res_d     = as_res;
                flags_d.c = as_c;
                flags_d.h = as_h;
                flags_d.pv = as_v;
                flags_d.n = is_sub;
            end
            OP_AND, OP_OR, OP_XOR: begin
                res_d      = bo_res;
                flags_d.c  = 1'b0;
                flags_d.n  = 1'b0;
                flags_d.h  = (op == OP_AND);
                flags_d.pv = ~^bo_res;
            end
            OP_RLC, OP_RRC, OP_SHL, OP_SHR: begin
                res_d      = bo_res;
                flags_d.c  = bo_c;
                flags_d.n  = 1'b0;
                flags_d.h  = 1'b0;
                flags_d.pv = ~^bo_res;
            end
            OP_BTST: begin
                flags_d.z = ~bo_bit;
                flags_d.h = 1'b1;
                flags_d.n = 1'b0;
            end
            OP_STC: begin
                flags_d.c = 1'b1;
                flags_d.h = 1'b0;
                flags_d.n = 1'b0;
            end
            OP_CMC: begin
                flags_d.c = ~flags_q.c;
                flags_d.h = 1'b0;
                flags_d.n = 1'b0;
            end
            OP_DADJ: begin
                msb_wide   = 1'b0;
                res_d      = {{(WIDE_W-NARROW_W){1'b0}}, bcd_res};
                flags_d.c  = bcd_c;
                flags_d.h  = bcd_h;
                flags_d.pv = ~^bcd_res;
            end
            default: res_d = a_m;
        endcase
        if (!(op inside {OP_BTST, OP_STC, OP_CMC, OP_PASS})) begin
            flags_d.s = msb_wide ? res_d[WIDE_W-1] : res_d[NARROW_W-1];
            flags_d.z = (res_d == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (wr_en_i) begin
            flags_q <= flags_d;
        end
    end

    assign res_o   = res_d;
    assign flags_o = {flags_q.s, flags_q.z, 1'b0, flags_q.h, 1'b0, flags_q.pv, flags_q.n, flags_q.c};

    // R2: flags hold without the strobe
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> (flags_o == $past(flags_o)));

    // R3: direction flag after subtract
    p_sub_sets_n_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (op_i == 4'd2 || op_i == 4'd3)) |=> flags_o[1]);

    // R6: zero flag tracks the arithmetic result seen at the edge
    p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && op_i <= 4'd3) |=> (flags_o[6] == ($past(res_o) == '0)));

    // R6: sign flag tracks the result MSB
    p_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && op_i <= 4'd3) |=>
        (flags_o[7] == ($past(wide_i) ? $past(res_o[WIDE_W-1]) : $past(res_o[NARROW_W-1]))));

    // R7: logic operations leave carry and N clear
    p_logic_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && op_i >= 4'd4 && op_i <= 4'd6) |=> (!flags_o[0] && !flags_o[1]));

    // R10: carry set and carry invert
    p_stc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && op_i == 4'd12) |=> flags_o[0]);
    p_cmc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && op_i == 4'd13) |=> (flags_o[0] != $past(flags_o[0])));

    // R11: decimal adjust keeps N and never drops a stored carry
    p_dadj_keeps_n_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && op_i == 4'd14) |=> (flags_o[1] == $past(flags_o[1])));
    p_dadj_carry_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && op_i == 4'd14 && flags_o[0]) |=> flags_o[0]);

    // R6: narrow results keep the upper byte clear
    p_narrow_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_i |-> (res_o[WIDE_W-1:NARROW_W] == '0));

endmodule

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;

    logic        clk;
    logic        rst_n;
    logic [15:0] a_i;
    logic [15:0] b_i;
    logic [3:0]  op_i;
    logic        wide_i;
    logic        wr_en_i;
    logic [15:0] res_o;
    logic [7:0]  flags_o;

    int n_checks;
    int n_errors;
    logic [7:0] exp_f;
    bit done;

    acc_alu dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_i     (a_i),
        .b_i     (b_i),
        .op_i    (op_i),
        .wide_i  (wide_i),
        .wr_en_i (wr_en_i),
        .res_o   (res_o),
        .flags_o (flags_o)
    );

    initial clk = 1'b0;
    always #2ns clk = ~clk;

    // expected {result, flags} from the requirements
    function automatic logic [23:0] model(input logic [15:0] a, input logic [15:0] b,
                                          input logic [3:0] op, input logic w, input logic [7:0] f);
        logic [15:0] mask, am, bm, r, corr;
        logic [16:0] t;
        logic s, z, h, pv, n, c, cc, sa, sb, sr, setsz;
        int W, idx;
        W = w ? 16 : 8;
        mask = w ? 16'hFFFF : 16'h00FF;
        am = a & mask; bm = b & mask;
        s = f[7]; z = f[6]; h = f[4]; pv = f[2]; n = f[1]; c = f[0];
        cc = (op == 4'd1 || op == 4'd3) ? c : 1'b0;
        setsz = 1'b1;
        r = am;
        case (op)
            4'd0, 4'd1: begin
                t = {1'b0, am} + {1'b0, bm} + {16'd0, cc};
                r = t[15:0] & mask; c = t[W]; h = ((am ^ bm ^ t[15:0]) >> (W - 4)) & 1;
                sa = am[W-1]; sb = bm[W-1]; sr = r[W-1];
                pv = (sa == sb) && (sr != sa); n = 1'b0;
            end
            4'd2, 4'd3: begin
                t = {1'b0, am} - {1'b0, bm} - {16'd0, cc};
                r = t[15:0] & mask; c = t[W]; h = ((am ^ bm ^ t[15:0]) >> (W - 4)) & 1;
                sa = am[W-1]; sb = bm[W-1]; sr = r[W-1];
                pv = (sa != sb) && (sr != sa); n = 1'b1;
            end
            4'd4, 4'd5, 4'd6: begin
                r = (op == 4'd4) ? (am & bm) : (op == 4'd5) ? (am | bm) : (am ^ bm);
                c = 1'b0; n = 1'b0; h = (op == 4'd4); pv = ~^r;
            end
            4'd7, 4'd8, 4'd9, 4'd10: begin
                case (op)
                    4'd7:    begin r = ((am << 1) | {15'd0, c}) & mask; c = am[W-1]; end
                    4'd8:    begin r = (am >> 1) | ({15'd0, c} << (W - 1)); c = am[0]; end
                    4'd9:    begin r = (am << 1) & mask; c = am[W-1]; end
                    default: begin r = am >> 1; c = am[0]; end
                endcase
                h = 1'b0; n = 1'b0; pv = ~^r;
            end
            4'd11: begin
                idx = w ? int'(b[3:0]) : int'(b[2:0]);
                z = ~am[idx]; h = 1'b1; n = 1'b0; setsz = 1'b0;
            end
            4'd12: begin c = 1'b1; h = 1'b0; n = 1'b0; setsz = 1'b0; end
            4'd13: begin c = ~c; h = 1'b0; n = 1'b0; setsz = 1'b0; end
            4'd14: begin
                W = 8; corr = 16'd0;
                if (a[3:0] > 4'd9 || h) corr = corr | 16'h06;
                if (a[7:0] > 8'h99 || c) begin corr = corr | 16'h60; c = 1'b1; end
                r = n ? ((a - corr) & 16'h00FF) : ((a + corr) & 16'h00FF);
                h = a[4] ^ r[4]; pv = ~^r;
            end
            default: setsz = 1'b0;
        endcase
        if (setsz) begin
            s = r[W-1]; z = (r == 16'd0);
        end
        return {r, s, z, 1'b0, h, 1'b0, pv, n, c};
    endfunction

    task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one operation: result checked before the edge, flags after it
    task automatic do_op(input logic [15:0] a, input logic [15:0] b, input logic [3:0] op,
                         input logic w, input logic we, input string req);
        logic [23:0] m;
        @(negedge clk);
        a_i = a; b_i = b; op_i = op; wide_i = w; wr_en_i = we;
        m = model(a, b, op, w, exp_f);
        #1ns;
        check(req, "result", res_o, m[23:8]);
        @(posedge clk);
        #1ns;
        if (we) exp_f = m[7:0];
        check(req, "flags", {8'd0, flags_o}, {8'd0, exp_f});
        wr_en_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; wr_en_i = 1'b0; a_i = '0; b_i = '0; op_i = 4'd0; wide_i = 1'b0;
        repeat (3) @(posedge clk);
        #1ns;
        check("R1", "flags in reset", {8'd0, flags_o}, 16'd0);
        @(negedge clk); rst_n = 1'b1;
        exp_f = 8'd0;
        do_op(16'h0000, 16'h0000, 4'd0, 1'b0, 1'b1, "R1");
    endtask

    task automatic t_add();
        do_op(16'h007F, 16'h0001, 4'd0, 1'b0, 1'b1, "R4");
        check("R4", "overflow flags const", {8'd0, flags_o}, 16'h0094);
        do_op(16'h00FF, 16'h0001, 4'd0, 1'b0, 1'b1, "R3");
        do_op(16'h0010, 16'h0020, 4'd1, 1'b0, 1'b1, "R3");
        do_op(16'h0080, 16'h0080, 4'd0, 1'b0, 1'b1, "R4");
        do_op(16'hAB0F, 16'hCD01, 4'd0, 1'b0, 1'b1, "R6");
        do_op(16'h0008, 16'h0008, 4'd0, 1'b0, 1'b1, "R5");
    endtask

    task automatic t_sub();
        do_op(16'h0000, 16'h0001, 4'd2, 1'b0, 1'b1, "R3");
        check("R3", "borrow flags const", {8'd0, flags_o}, 16'h0093);
        do_op(16'h0050, 16'h0010, 4'd3, 1'b0, 1'b1, "R3");
        do_op(16'h0080, 16'h0001, 4'd2, 1'b0, 1'b1, "R4");
        do_op(16'h0042, 16'h0042, 4'd2, 1'b0, 1'b1, "R6");
    endtask

    task automatic t_wide();
        do_op(16'h0FFF, 16'h0001, 4'd0, 1'b1, 1'b1, "R5");
        do_op(16'h000F, 16'h0001, 4'd0, 1'b1, 1'b1, "R5");
        do_op(16'h7FFF, 16'h0001, 4'd0, 1'b1, 1'b1, "R4");
        do_op(16'hFFFF, 16'h0001, 4'd1, 1'b1, 1'b1, "R3");
        do_op(16'h1000, 16'h0001, 4'd2, 1'b1, 1'b1, "R5");
        do_op(16'h0000, 16'h0001, 4'd3, 1'b1, 1'b1, "R6");
    endtask

    task automatic t_logic();
        do_op(16'h00F0, 16'h003C, 4'd4, 1'b0, 1'b1, "R7");
        do_op(16'h0001, 16'h0002, 4'd5, 1'b0, 1'b1, "R7");
        do_op(16'h00AA, 16'h00AA, 4'd6, 1'b0, 1'b1, "R7");
        do_op(16'h8001, 16'h0100, 4'd5, 1'b1, 1'b1, "R7");
    endtask

    task automatic t_rotate();
        do_op(16'h0000, 16'h0000, 4'd12, 1'b0, 1'b1, "R8");
        do_op(16'h0080, 16'h0000, 4'd7, 1'b0, 1'b1, "R8");
        do_op(16'h0001, 16'h0000, 4'd8, 1'b0, 1'b1, "R8");
        do_op(16'h0000, 16'h0000, 4'd8, 1'b0, 1'b1, "R8");
        do_op(16'h00C3, 16'h0000, 4'd9, 1'b0, 1'b1, "R8");
        do_op(16'h0003, 16'h0000, 4'd10, 1'b0, 1'b1, "R8");
        do_op(16'h8000, 16'h0000, 4'd7, 1'b1, 1'b1, "R8");
        do_op(16'h0001, 16'h0000, 4'd8, 1'b1, 1'b1, "R8");
    endtask

    task automatic t_bit();
        do_op(16'h0008, 16'h0003, 4'd11, 1'b0, 1'b1, "R9");
        do_op(16'h0008, 16'h0002, 4'd11, 1'b0, 1'b1, "R9");
        do_op(16'h0400, 16'h000A, 4'd11, 1'b1, 1'b1, "R9");
        do_op(16'h0400, 16'h000A, 4'd11, 1'b0, 1'b1, "R9");
    endtask

    task automatic t_carry();
        do_op(16'h0055, 16'h0000, 4'd13, 1'b0, 1'b1, "R10");
        do_op(16'h0055, 16'h0000, 4'd13, 1'b0, 1'b1, "R10");
        do_op(16'h1234, 16'h0000, 4'd12, 1'b1, 1'b1, "R10");
        do_op(16'h1234, 16'h0000, 4'd15, 1'b1, 1'b1, "R2");
    endtask

    task automatic t_bcd();
        do_op(16'h0015, 16'h0027, 4'd0, 1'b0, 1'b1, "R11");
        do_op(16'h003C, 16'h0000, 4'd14, 1'b0, 1'b1, "R11");
        check("R11", "adjust flags const", {8'd0, flags_o}, 16'h0014);
        do_op(16'h0099, 16'h0001, 4'd0, 1'b0, 1'b1, "R11");
        do_op(16'h009A, 16'h0000, 4'd14, 1'b0, 1'b1, "R11");
        do_op(16'h0042, 16'h0019, 4'd2, 1'b0, 1'b1, "R11");
        do_op(16'h0029, 16'h0000, 4'd14, 1'b0, 1'b1, "R11");
        do_op(16'h0010, 16'h0020, 4'd2, 1'b0, 1'b1, "R11");
        do_op(16'h00F0, 16'h0000, 4'd14, 1'b1, 1'b1, "R11");
    endtask

    task automatic t_hold();
        do_op(16'h00FF, 16'h0001, 4'd0, 1'b0, 1'b1, "R2");
        do_op(16'h0001, 16'h0001, 4'd2, 1'b0, 1'b0, "R2");
        do_op(16'h00F0, 16'h000F, 4'd4, 1'b0, 1'b0, "R2");
        do_op(16'h0001, 16'h0001, 4'd13, 1'b0, 1'b0, "R2");
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        n_checks = 0; n_errors = 0; done = 1'b0;
        t_reset();
        t_add();
        t_sub();
        t_wide();
        t_logic();
        t_rotate();
        t_bit();
        t_carry();
        t_bcd();
        t_hold();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule